// File: doc/BRIEF.md
# Embedded Operation Status Tracker

This block sits beside the command decoder of a word-wide flash array. The decoder hands it a single-cycle request when a program or erase command sequence completes. The block then times the internal operation by counting clock cycles. The program and erase durations are separate parameters. While the operation runs, the block raises a busy flag and reports progress through ordinary array reads: two data bits are replaced with status.

The poll bit reports one of two values. During a program it carries the inverse of the same bit of the word being written. During an erase it reads 0. The toggle bit changes value on each read strobe, where a read strobe is output enable going low while the chip is selected. A host that polls therefore sees the bit alternate until the work is done.

When the count runs out, the block emits a one-cycle completion pulse and goes back to plain array reads with no host action. The status overlay applies only to asynchronous-mode reads. An active-low reset abandons any operation in flight.

Top module: `op_status_tracker`

## Requirements
- R1: While reset is held and after its release with no request, `busy` and `done` are 0 and `rd_data` equals `array_rdata`.
- R2: A `start` pulse taken while idle makes `busy` read 1 on exactly PROG_CYCLES rising edges after the accepting edge when `op_is_erase` = 0, or ERASE_CYCLES edges when it is 1.
- R3: `done` is 1 for exactly one cycle, the cycle in which `busy` first reads 0 after an operation that ran to its end. From then on, `rd_data` equals `array_rdata` with no host action.
- R4: During a program with `async_mode` = 1, bit POLL_BIT (7 by default) of `rd_data` is the inverse of bit POLL_BIT of the `wr_data` captured with the request.
- R5: During an erase with `async_mode` = 1, bit POLL_BIT of `rd_data` is 0. After completion it shows the array value again, 1 for an erased word.
- R6: The toggle bit TOGGLE_BIT (6 by default) is cleared when a request is taken. Each read strobe during the operation inverts it, so the first read shows 1, the next 0, and so on. A read strobe is a 1-to-0 change of `oe_n`, seen at a clock edge, while `cs_n` = 0 and `async_mode` = 1.
- R7: The toggle bit keeps its value when `oe_n` stays low across several clocks, and when `oe_n` pulses while `cs_n` = 1.
- R8: With `async_mode` = 0, `rd_data` equals `array_rdata` even during an operation, and reads in that mode do not advance the toggle bit.
- R9: A `start` arriving while `busy` = 1 is ignored: the running operation keeps its type, its captured poll bit and its end time.
- R10: Driving `rst_n` low during an operation clears `busy` at once. No `done` pulse follows, and `rd_data` equals `array_rdata`.
- R11: Every bit other than POLL_BIT and TOGGLE_BIT of `rd_data` always equals the same bit of `array_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any operation |
| start | input | 1 | One-cycle request from the command decoder |
| op_is_erase | input | 1 | Request type: 1 erase, 0 program |
| wr_data | input | DATA_W | Word written by the program command |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| async_mode | input | 1 | 1 selects asynchronous reads, which carry status |
| array_rdata | input | DATA_W | Word read from the array |
| rd_data | output | DATA_W | Read word with status bits overlaid while busy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the natural end of an operation |

## Verification
The assertions assume four things about the inputs:
- `rst_n` stays low across at least one rising clock edge.
- `start` is a single-cycle pulse.
- Each `oe_n` low phase and each high phase lasts at least one full clock, so `clk` sees every read strobe.
- `cs_n` and `oe_n` change only between edges.

The bench drives every input on the falling clock edge. Each read holds `oe_n` low for two cycles and high for one. Reset is held for several edges.

With these limits in place, the toggle checks count strobes exactly. The poll and toggle values expected by the bench follow directly from the number of reads issued since the request was taken.

// File: rtl/op_status_pkg.sv
package op_status_pkg;

   typedef enum logic {
      OPK_PROGRAM = 1'b0,
      OPK_ERASE   = 1'b1
   } op_kind_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ost_timer.sv
module ost_timer
   import op_status_pkg::*;
#(
   parameter int PROG_CYCLES  = 500,
   parameter int ERASE_CYCLES = 50000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     op_is_erase,
   input  logic     wr_bit,
   output logic     accept,
   output logic     busy,
   output logic     done,
   output op_kind_e kind,
   output logic     poll_bit
);

   localparam int MAXC  = max_of(PROG_CYCLES, ERASE_CYCLES);
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
   localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("ost_timer: PROG_CYCLES must be at least 1");
   end
   if (ERASE_CYCLES < 1) begin : g_bad_erase
      $error("ost_timer: ERASE_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;
   op_kind_e         kind_q;
   logic             pbit_q;

   assign accept = start && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         kind_q <= OPK_PROGRAM;
         pbit_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            kind_q <= op_is_erase ? OPK_ERASE : OPK_PROGRAM;
            pbit_q <= wr_bit;
            cnt_q  <= op_is_erase ? ERASE_LOAD : PROG_LOAD;
         end else if (busy_q) begin
            if (cnt_q == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign kind     = kind_q;
   assign poll_bit = pbit_q;

   // R3
   done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

   // R2
   busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> (!busy_q || $past(start)));

   // R9
   kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start && cnt_q != '0) |=> (busy_q && $stable(kind_q) && $stable(pbit_q)));

endmodule

// File: rtl/ost_toggle.sv
module ost_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic busy,
   input  logic cs_n,
   input  logic oe_n,
   input  logic async_mode,
   output logic tog
);

   logic oe_q;
   logic tog_q;
   logic strobe;

   assign strobe = oe_q && !oe_n && !cs_n && async_mode && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q  <= 1'b1;
         tog_q <= 1'b0;
      end else begin
         oe_q <= oe_n;
         if (clear) begin
            tog_q <= 1'b0;
         end else if (strobe) begin
            tog_q <= ~tog_q;
         end
      end
   end

   assign tog = tog_q;

   // R7
   tog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !clear) |=> $stable(tog_q));

   // R6
   tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !clear) |=> (tog_q != $past(tog_q)));

endmodule

// File: rtl/ost_overlay.sv
module ost_overlay
   import op_status_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input  logic [DATA_W-1:0] array_rdata,
   input  logic              busy,
   input  logic              async_mode,
   input  op_kind_e          kind,
   input  logic              poll_bit,
   input  logic              tog,
   output logic [DATA_W-1:0] rd_data
);

   logic show_status;
   logic poll_val;

   assign show_status = busy && async_mode;
   assign poll_val    = (kind == OPK_ERASE) ? 1'b0 : ~poll_bit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
         assign rd_data[i] = show_status ? poll_val : array_rdata[i];
      end else if (i == TOGGLE_BIT) begin : g_tog
         assign rd_data[i] = show_status ? tog : array_rdata[i];
      end else begin : g_pass
         assign rd_data[i] = array_rdata[i];
      end
   end

endmodule

// File: rtl/op_status_tracker.sv
module op_status_tracker
   import op_status_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int POLL_BIT     = 7,
   parameter int TOGGLE_BIT   = 6,
   parameter int PROG_CYCLES  = 500,
   parameter int ERASE_CYCLES = 50000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_is_erase,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              async_mode,
   input  logic [DATA_W-1:0] array_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done
);

   if (POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W || POLL_BIT == TOGGLE_BIT) begin : g_bad_bits
      $error("op_status_tracker: status bit positions out of range or equal");
   end

   logic     accept;
   op_kind_e kind;
   logic     poll_bit;
   logic     tog;

   ost_timer #(
      .PROG_CYCLES  (PROG_CYCLES),
      .ERASE_CYCLES (ERASE_CYCLES)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .op_is_erase (op_is_erase),
      .wr_bit      (wr_data[POLL_BIT]),
      .accept      (accept),
      .busy        (busy),
      .done        (done),
      .kind        (kind),
      .poll_bit    (poll_bit)
   );

   ost_toggle u_toggle (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .busy       (busy),
      .cs_n       (cs_n),
      .oe_n       (oe_n),
      .async_mode (async_mode),
      .tog        (tog)
   );

   ost_overlay #(
      .DATA_W     (DATA_W),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT)
   ) u_overlay (
      .array_rdata (array_rdata),
      .busy        (busy),
      .async_mode  (async_mode),
      .kind        (kind),
      .poll_bit    (poll_bit),
      .tog         (tog),
      .rd_data     (rd_data)
   );

   // R5
   erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && async_mode && kind == OPK_ERASE) |-> !rd_data[POLL_BIT]);

   // R3
   idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rd_data == array_rdata));

   // R8
   sync_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !async_mode |-> (rd_data == array_rdata));

endmodule

// File: tb/sim_op_status_tracker.sv
module sim_op_status_tracker;

   localparam int DW  = 16;
   localparam int PC  = 20;
   localparam int EC  = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op_is_erase = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          cs_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          async_mode = 1'b1;
   logic [DW-1:0] arr = 16'hA5C3;
   logic [DW-1:0] rd_data;
   logic          busy;
   logic          done;

   int n_checks = 0;
   int n_fail   = 0;
   int bc       = 0;
   int done_cnt = 0;

   always #2 clk = ~clk;

   op_status_tracker #(
      .DATA_W (DW), .POLL_BIT (7), .TOGGLE_BIT (6),
      .PROG_CYCLES (PC), .ERASE_CYCLES (EC)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .start (start), .op_is_erase (op_is_erase),
      .wr_data (wr_data), .cs_n (cs_n), .oe_n (oe_n), .async_mode (async_mode),
      .array_rdata (arr), .rd_data (rd_data), .busy (busy), .done (done)
   );

   always @(posedge clk) begin
      if (busy) bc++;
      if (done) done_cnt++;
   end

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   task automatic launch(input logic er, input logic [DW-1:0] w);
      @(negedge clk);
      start = 1'b1; op_is_erase = er; wr_data = w; bc = 0;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic do_read(output logic [DW-1:0] v);
      cs_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      v = rd_data;
      oe_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_done(input string req, input int dur);
      int g = 0;
      while (!done && g < 500) begin
         @(negedge clk);
         g++;
      end
      check(req, {15'd0, done}, 16'd1);
      check(req, {15'd0, busy}, 16'd0);
      check(req, 16'(bc), 16'(dur));
      check(req, rd_data, arr);
      @(negedge clk);
      check(req, {15'd0, done}, 16'd0);
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end

   initial begin
      logic [DW-1:0] v;
      logic [DW-1:0] pats [4] = '{16'h0000, 16'h0080, 16'hFF7F, 16'hFFFF};

      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1", {14'd0, busy, done}, 16'd0);
      check("R1", rd_data, arr);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", {14'd0, busy, done}, 16'd0);
      check("R1", rd_data, arr);

      // R2 R3 duration sweep over type and written word
      for (int e = 0; e < 2; e++) begin
         for (int p = 0; p < 4; p++) begin
            arr = pats[p] ^ 16'h5A5A;
            launch(e[0], pats[p]);
            wait_done(e ? "R2 erase" : "R2 program", e ? EC : PC);
         end
      end

      // R4 R6 R11 program poll and toggle sweep
      for (int p = 0; p < 4; p++) begin
         launch(1'b0, pats[p]);
         for (int k = 1; k <= 5; k++) begin
            arr = pats[p] ^ 16'(k * 16'h1111);
            do_read(v);
            check("R4", {15'd0, v[7]}, {15'd0, ~pats[p][7]});
            check("R6", {15'd0, v[6]}, {15'd0, k[0]});
            check("R11", v & 16'hFF3F, arr & 16'hFF3F);
         end
         wait_done("R3", PC);
      end

      // R5 erase poll reads 0, then true data
      arr = 16'h80FF;
      launch(1'b1, 16'hFFFF);
      for (int k = 1; k <= 4; k++) begin
         do_read(v);
         check("R5", {15'd0, v[7]}, 16'd0);
         check("R6", {15'd0, v[6]}, {15'd0, k[0]});
      end
      wait_done("R5", EC);
      do_read(v);
      check("R5", v, 16'h80FF);

      // R7 no strobe: deselected pulses and held output enable
      arr = 16'h0000;
      launch(1'b0, 16'h0000);
      do_read(v);
      check("R7", {15'd0, v[6]}, 16'd1);
      cs_n = 1'b1; oe_n = 1'b0;
      @(negedge clk); @(negedge clk);
      oe_n = 1'b1;
      @(negedge clk);
      oe_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      check("R7", {15'd0, rd_data[6]}, 16'd1);
      repeat (3) @(negedge clk);
      check("R7", {15'd0, rd_data[6]}, 16'd1);
      oe_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
      do_read(v);
      check("R7", {15'd0, v[6]}, 16'd0);
      wait_done("R3", PC);

      // R8 synchronous mode: no overlay, no toggle advance
      arr = 16'h1234;
      async_mode = 1'b0;
      launch(1'b0, 16'h0000);
      for (int k = 0; k < 3; k++) begin
         do_read(v);
         check("R8", v, 16'h1234);
      end
      async_mode = 1'b1;
      do_read(v);
      check("R8", {15'd0, v[6]}, 16'd1);
      check("R8", {15'd0, v[7]}, 16'd1);
      wait_done("R3", PC);

      // R9 request while busy is ignored
      arr = 16'h00FF;
      launch(1'b0, 16'h0000);
      repeat (4) @(negedge clk);
      start = 1'b1; op_is_erase = 1'b1; wr_data = 16'h0080;
      @(negedge clk);
      start = 1'b0;
      do_read(v);
      check("R9", {15'd0, v[7]}, 16'd1);
      wait_done("R9", PC);

      // R10 reset aborts an erase
      arr = 16'h4321;
      launch(1'b1, 16'h0000);
      repeat (6) @(negedge clk);
      done_cnt = 0;
      rst_n = 1'b0;
      #1;
      check("R10", {15'd0, busy}, 16'd0);
      check("R10", rd_data, arr);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      repeat (EC + 10) @(negedge clk);
      check("R10", 16'(done_cnt), 16'd0);
      check("R10", {15'd0, busy}, 16'd0);

      summary();
   end

endmodule